// File: doc/BRIEF.md
# EDO Page-Mode DRAM Sequencer

This block sits between a host that issues single-word reads and writes and a 256K x 16 extended-data-out DRAM. Each host request carries an 18-bit word address, a 16-bit write word and two byte enables. The block turns each request into the row strobe, the two byte-lane column strobes, and the write-enable and output-enable sequences the memory needs. The row and the column share one 9-bit multiplexed address bus.

After an access the row stays open. A later request to the same row is served with a single column cycle, and RAS does not toggle. A request to another row closes the page, waits out the precharge, and opens the new row. A guard counts how long RAS has been low and closes the page before the page-mode pulse limit is reached. Refresh is generated elsewhere: a separate refresh engine asks for the memory with a level request. This block closes the page, lets the precharge finish, and grants the bus until the request drops.

Every memory timing is a parameter counted in clock cycles. Read data is captured one cycle after the column strobe rises. This relies on extended data-out keeping the word valid after CAS returns high.

Top module: `edo_page_ctrl`

## Requirements
- R1: After reset, RAS, both column strobes, write enable and output enable are high. The data bus driver is off, rd_valid and ref_gnt are low, and req_ready is high.
- R2: The row is req_addr[17:9], placed on dram_addr when RAS falls. The column is req_addr[8:0], placed on dram_addr when a column strobe falls.
- R3: On a newly opened row, the first column strobe falls exactly RCD_CYC+1 cycles after RAS falls. dram_addr holds the column for at least one cycle before any column strobe falls.
- R4: A request to the open row is served without RAS rising. Between two column cycles both column strobes stay high for at least two cycles. A read hit returns rd_valid N+2 cycles after acceptance.
- R5: req_be[0] drives the low-lane strobe (bits 7:0) and req_be[1] drives the high-lane strobe (bits 15:8). A write changes only the enabled lanes. Lanes that a read did not enable return zero on rd_data.
- R6: A write is an early write. Write enable is low and the data driver is on from the cycle before the column strobe falls until it rises, and output enable stays high.
- R7: Column strobes stay low for exactly N cycles, where N is the largest of CAC_CYC, AA_CYC-2, RAC_CYC-RCD_CYC-2 and 1. rd_valid is a one-cycle pulse. A read that must open its row returns RCD_CYC+N+2 cycles after acceptance.
- R8: A request to a row other than the open one closes the page. RAS then stays high for at least RP_CYC cycles before the new row opens.
- R9: RAS never stays low for more than RASP_CYC consecutive cycles. With no requests at all, the page closes by itself before that limit.
- R10: While ref_req is high, no host request is accepted. The open page is closed, and ref_gnt rises only while RAS and both column strobes are high. After ref_req drops, RAS stays high for at least RP_CYC cycles before the next row opens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address, row in upper 9 bits |
| req_be | input | 2 | Byte enables, bit 0 low lane |
| req_wdata | input | 16 | Write word |
| rd_data | output | 16 | Captured read word, disabled lanes zero |
| rd_valid | output | 1 | One-cycle read-return pulse |
| ref_req | input | 1 | Refresh engine requests the memory |
| ref_gnt | output | 1 | Memory handed to the refresh engine |
| dram_ras_n | output | 1 | Row strobe |
| dram_lcas_n | output | 1 | Low-lane column strobe |
| dram_ucas_n | output | 1 | High-lane column strobe |
| dram_we_n | output | 1 | Write enable |
| dram_oe_n | output | 1 | Output enable |
| dram_addr | output | 9 | Multiplexed row/column address |
| dram_dq_out | output | 16 | Write data to memory |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | 16 | Read data from memory |

## Verification
Every result has a fixed due cycle counted from the clock edge that accepts the request. rd_valid is due N+2 edges later on a page hit and RCD_CYC+N+2 edges later when the row must first be opened. The bench stamps the acceptance edge and requires the pulse at exactly that count. Strobe spacings are measured on the pins by a monitor that samples on the falling clock edge: RAS high and low runs, the RAS-to-CAS distance, CAS width and CAS precharge. These spacings are compared with values the bench derives from its own parameters. Data is checked against a shadow copy that the bench keeps, through a memory model that latches row and column on the strobe edges.

// File: rtl/edo_page_pkg.sv
package edo_page_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_RCD, S_COL, S_CAS, S_PAGE, S_PRE, S_REF
  } seq_state_t;

  // column strobe low time: covers CAS access, column access and row access
  function automatic int unsigned cas_low_cycles(input int unsigned cac,
                                                 input int unsigned aa,
                                                 input int unsigned rac,
                                                 input int unsigned rcd);
    int unsigned n;
    n = cac;
    if (aa > 2 && aa - 2 > n) n = aa - 2;
    if (rac > rcd + 2 && rac - rcd - 2 > n) n = rac - rcd - 2;
    if (n < 1) n = 1;
    return n;
  endfunction

  // load value for the page wait: CAS high = page cycles + one column setup cycle
  function automatic int unsigned page_wait_load(input int unsigned cp);
    int unsigned w;
    w = (cp > 1) ? cp - 1 : 1;
    return w - 1;
  endfunction

  // load value for the precharge wait: RAS high = load + 2 cycles at least
  function automatic int unsigned pre_wait_load(input int unsigned rp);
    return (rp > 2) ? rp - 2 : 0;
  endfunction

  // cycles kept in hand before the RAS low limit
  function automatic int unsigned rasp_margin(input int unsigned n);
    return n + 3;
  endfunction

endpackage

// File: rtl/edo_row_track.sv
module edo_row_track #(
  parameter int ROW_W = 9,
  parameter int COL_W = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ROW_W+COL_W-1:0]   addr,
  input  logic                     load,
  output logic [ROW_W-1:0]         row,
  output logic [COL_W-1:0]         col,
  output logic                     hit
);
  logic [ROW_W-1:0] open_row;

  assign row = addr[ROW_W+COL_W-1:COL_W];
  assign col = addr[COL_W-1:0];
  assign hit = (row == open_row);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) open_row <= '0;
    else if (load) open_row <= row;
  end
endmodule

// File: rtl/edo_rasp_guard.sv
module edo_rasp_guard #(
  parameter int RASP_CYC = 9900,
  parameter int MARGIN   = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_n,
  output logic near
);
  localparam int CW = $clog2(RASP_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(RASP_CYC);
  localparam logic [CW-1:0] TRIP  = CW'(RASP_CYC - MARGIN);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_cnt <= '0;
    else if (ras_n) low_cnt <= '0;
    else if (low_cnt != LIMIT) low_cnt <= low_cnt + 1'b1;
  end

  assign near = (low_cnt >= TRIP);

  // R9: the RAS low run never reaches the page pulse limit
  a_r9_rasp_limit: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> (low_cnt < LIMIT));
endmodule

// File: rtl/edo_seq.sv
module edo_seq
  import edo_page_pkg::*;
#(
  parameter int ROW_W   = 9,
  parameter int COL_W   = 9,
  parameter int DATA_W  = 16,
  parameter int RCD_CYC = 2,
  parameter int CAC_CYC = 2,
  parameter int AA_CYC  = 3,
  parameter int RAC_CYC = 6,
  parameter int CP_CYC  = 1,
  parameter int RP_CYC  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_be,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [ROW_W-1:0]  row_in,
  input  logic [COL_W-1:0]  col_in,
  input  logic              row_hit,
  output logic              row_load,
  input  logic              rasp_near,
  input  logic              ref_req,
  output logic              ref_gnt,
  output logic              dram_ras_n,
  output logic              dram_lcas_n,
  output logic              dram_ucas_n,
  output logic              dram_we_n,
  output logic              dram_oe_n,
  output logic [ROW_W-1:0]  dram_addr,
  output logic [DATA_W-1:0] dram_dq_out,
  output logic              dram_dq_oe,
  input  logic [DATA_W-1:0] dram_dq_in,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  localparam int LANE_W   = DATA_W / 2;
  localparam int CAS_N    = cas_low_cycles(CAC_CYC, AA_CYC, RAC_CYC, RCD_CYC);
  localparam int PG_LD_I  = page_wait_load(CP_CYC);
  localparam int PRE_LD_I = pre_wait_load(RP_CYC);
  localparam int TMAX     = (CAS_N > RCD_CYC) ? ((CAS_N > PRE_LD_I) ? CAS_N : PRE_LD_I)
                                              : ((RCD_CYC > PRE_LD_I) ? RCD_CYC : PRE_LD_I);
  localparam int CNT_W    = $clog2(TMAX + 2);
  localparam logic [CNT_W-1:0] RCD_LD = CNT_W'(RCD_CYC - 1);
  localparam logic [CNT_W-1:0] CAS_LD = CNT_W'(CAS_N - 1);
  localparam logic [CNT_W-1:0] PG_LD  = CNT_W'(PG_LD_I);
  localparam logic [CNT_W-1:0] PRE_LD = CNT_W'(PRE_LD_I);

  function automatic logic [DATA_W-1:0] lane_mask(input logic [1:0] be);
    return {{LANE_W{be[1]}}, {LANE_W{be[0]}}};
  endfunction

  seq_state_t       state;
  logic [CNT_W-1:0] tcnt;
  logic             wr_q;
  logic [1:0]       be_q;
  logic [COL_W-1:0] col_q;
  logic             cap_pend;

  // named events for the checks below
  logic cnt_zero, accept, close_now, cas_act;
  assign cnt_zero  = (tcnt == '0);
  assign close_now = ref_req || rasp_near || (req_valid && !row_hit);
  assign cas_act   = !dram_lcas_n || !dram_ucas_n;

  always_comb begin
    req_ready = 1'b0;
    if (state == S_IDLE) req_ready = !ref_req;
    else if (state == S_PAGE) req_ready = cnt_zero && !ref_req && !rasp_near && row_hit;
  end
  assign accept   = req_valid && req_ready;
  assign row_load = accept && (state == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      tcnt        <= '0;
      wr_q        <= 1'b0;
      be_q        <= 2'b00;
      col_q       <= '0;
      cap_pend    <= 1'b0;
      ref_gnt     <= 1'b0;
      dram_ras_n  <= 1'b1;
      dram_lcas_n <= 1'b1;
      dram_ucas_n <= 1'b1;
      dram_we_n   <= 1'b1;
      dram_oe_n   <= 1'b1;
      dram_addr   <= '0;
      dram_dq_out <= '0;
      dram_dq_oe  <= 1'b0;
      rd_data     <= '0;
      rd_valid    <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      if (cap_pend) begin
        rd_data   <= dram_dq_in & lane_mask(be_q);
        rd_valid  <= 1'b1;
        cap_pend  <= 1'b0;
        dram_oe_n <= 1'b1;
      end
      case (state)
        S_IDLE: begin
          if (ref_req) begin
            ref_gnt <= 1'b1;
            state   <= S_REF;
          end else if (accept) begin
            dram_ras_n  <= 1'b0;
            dram_addr   <= ROW_W'(row_in);
            wr_q        <= req_write;
            be_q        <= req_be;
            col_q       <= col_in;
            dram_dq_out <= req_wdata;
            tcnt        <= RCD_LD;
            state       <= S_RCD;
          end
        end
        S_RCD: begin
          if (cnt_zero) begin
            dram_addr  <= ROW_W'(col_q);
            dram_we_n  <= !wr_q;
            dram_oe_n  <= wr_q;
            dram_dq_oe <= wr_q;
            state      <= S_COL;
          end else begin
            tcnt <= tcnt - 1'b1;
          end
        end
        S_COL: begin
          dram_lcas_n <= !be_q[0];
          dram_ucas_n <= !be_q[1];
          tcnt        <= CAS_LD;
          state       <= S_CAS;
        end
        S_CAS: begin
          if (cnt_zero) begin
            dram_lcas_n <= 1'b1;
            dram_ucas_n <= 1'b1;
            dram_we_n   <= 1'b1;
            dram_dq_oe  <= 1'b0;
            cap_pend    <= !wr_q;
            tcnt        <= PG_LD;
            state       <= S_PAGE;
          end else begin
            tcnt <= tcnt - 1'b1;
          end
        end
        S_PAGE: begin
          if (close_now) begin
            dram_ras_n <= 1'b1;
            tcnt       <= PRE_LD;
            state      <= S_PRE;
          end else if (!cnt_zero) begin
            tcnt <= tcnt - 1'b1;
          end else if (accept) begin
            wr_q        <= req_write;
            be_q        <= req_be;
            col_q       <= col_in;
            dram_addr   <= ROW_W'(col_in);
            dram_we_n   <= !req_write;
            dram_oe_n   <= req_write;
            dram_dq_oe  <= req_write;
            dram_dq_out <= req_wdata;
            state       <= S_COL;
          end
        end
        S_PRE: begin
          if (cnt_zero) state <= S_IDLE;
          else tcnt <= tcnt - 1'b1;
        end
        S_REF: begin
          if (!ref_req) begin
            ref_gnt <= 1'b0;
            tcnt    <= PRE_LD;
            state   <= S_PRE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R3: the column is settled on the bus before a column strobe falls
  a_r3_col_settled: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_act) |-> $stable(dram_addr));

  // R6: early write, WE already low and data driven, outputs disabled
  a_r6_early_write: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cas_act) && !dram_we_n) |-> ($past(!dram_we_n) && dram_dq_oe && dram_oe_n));

  // R4: a column strobe is only active inside an open row
  a_r4_cas_in_row: assert property (@(posedge clk) disable iff (!rst_n)
    cas_act |-> !dram_ras_n);

  // R10: while granted, the memory is left quiet and no host access is taken
  a_r10_grant_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ref_gnt |-> (dram_ras_n && !cas_act && !req_ready));

  // R7: read return is a single-cycle pulse
  a_r7_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  // R8: once RAS rises it stays high on the next cycle too
  a_r8_pre_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dram_ras_n) |=> dram_ras_n);
endmodule

// File: rtl/edo_page_ctrl.sv
module edo_page_ctrl
  import edo_page_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int DATA_W   = 16,
  parameter int RCD_CYC  = 2,
  parameter int CAC_CYC  = 2,
  parameter int AA_CYC   = 3,
  parameter int RAC_CYC  = 6,
  parameter int CP_CYC   = 1,
  parameter int RP_CYC   = 4,
  parameter int RASP_CYC = 9900
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [1:0]           req_be,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 rd_valid,
  input  logic                 ref_req,
  output logic                 ref_gnt,
  output logic                 dram_ras_n,
  output logic                 dram_lcas_n,
  output logic                 dram_ucas_n,
  output logic                 dram_we_n,
  output logic                 dram_oe_n,
  output logic [ADDR_W/2-1:0]  dram_addr,
  output logic [DATA_W-1:0]    dram_dq_out,
  output logic                 dram_dq_oe,
  input  logic [DATA_W-1:0]    dram_dq_in
);
  localparam int COL_W  = ADDR_W / 2;
  localparam int ROW_W  = ADDR_W - COL_W;
  localparam int CAS_N  = cas_low_cycles(CAC_CYC, AA_CYC, RAC_CYC, RCD_CYC);
  localparam int MARGIN = rasp_margin(CAS_N);

  logic [ROW_W-1:0] row_w;
  logic [COL_W-1:0] col_w;
  logic             hit_w, load_w, near_w;

  edo_row_track #(.ROW_W(ROW_W), .COL_W(COL_W)) u_row (
    .clk(clk), .rst_n(rst_n), .addr(req_addr), .load(load_w),
    .row(row_w), .col(col_w), .hit(hit_w)
  );

  edo_rasp_guard #(.RASP_CYC(RASP_CYC), .MARGIN(MARGIN)) u_guard (
    .clk(clk), .rst_n(rst_n), .ras_n(dram_ras_n), .near(near_w)
  );

  edo_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
    .RCD_CYC(RCD_CYC), .CAC_CYC(CAC_CYC), .AA_CYC(AA_CYC),
    .RAC_CYC(RAC_CYC), .CP_CYC(CP_CYC), .RP_CYC(RP_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_be(req_be), .req_wdata(req_wdata),
    .row_in(row_w), .col_in(col_w), .row_hit(hit_w), .row_load(load_w),
    .rasp_near(near_w), .ref_req(ref_req), .ref_gnt(ref_gnt),
    .dram_ras_n(dram_ras_n), .dram_lcas_n(dram_lcas_n), .dram_ucas_n(dram_ucas_n),
    .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_addr(dram_addr),
    .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );
endmodule

// File: tb/edo_page_ctrl_tb.sv
module edo_page_ctrl_tb;
  localparam int P_RCD = 2, P_CAC = 2, P_AA = 3, P_RAC = 7;
  localparam int P_CP = 1, P_RP = 4, P_RASP = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, ref_req = 1'b0;
  logic [17:0] req_addr = '0;
  logic [1:0]  req_be = 2'b11;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rd_valid, ref_gnt;
  logic [15:0] rd_data, dram_dq_out, dram_dq_in;
  logic dram_ras_n, dram_lcas_n, dram_ucas_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [8:0] dram_addr;

  int checks = 0, errors = 0, cyc = 0, acc_cyc = 0;

  edo_page_ctrl #(.RCD_CYC(P_RCD), .CAC_CYC(P_CAC), .AA_CYC(P_AA), .RAC_CYC(P_RAC),
                  .CP_CYC(P_CP), .RP_CYC(P_RP), .RASP_CYC(P_RASP)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rd_data(rd_data), .rd_valid(rd_valid), .ref_req(ref_req), .ref_gnt(ref_gnt),
    .dram_ras_n(dram_ras_n), .dram_lcas_n(dram_lcas_n), .dram_ucas_n(dram_ucas_n),
    .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_addr(dram_addr),
    .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // column strobe width the bench expects, derived in its own terms
  function automatic int strobe_width();
    int w = P_CAC;
    if (P_AA - 2 > w) w = P_AA - 2;
    if (P_RAC - P_RCD - 2 > w) w = P_RAC - P_RCD - 2;
    return (w < 1) ? 1 : w;
  endfunction
  localparam int NW = strobe_width();

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model: latches row and column on strobe edges
  logic [15:0] mem [int];
  logic [15:0] shadow [int];
  logic [8:0]  m_row = '0;
  logic [15:0] m_hold = 16'hDEAD;
  wire cas_both_n = dram_lcas_n & dram_ucas_n;
  assign dram_dq_in = dram_oe_n ? 16'hBEEF : m_hold;

  always @(negedge dram_ras_n) m_row = dram_addr;
  always @(posedge dram_ras_n) m_hold = 16'hDEAD;
  always @(negedge cas_both_n) begin
    int key;
    logic [15:0] cur;
    key = int'({m_row, dram_addr});
    cur = mem.exists(key) ? mem[key] : 16'h0000;
    if (!dram_we_n) begin
      chk(dram_dq_oe, "R6 data driven at strobe", dram_dq_oe, 1);
      if (!dram_lcas_n) cur[7:0]  = dram_dq_out[7:0];
      if (!dram_ucas_n) cur[15:8] = dram_dq_out[15:8];
      mem[key] = cur;
      m_hold = 16'hDEAD;
    end else begin
      m_hold = cur;
      if (dram_lcas_n) m_hold[7:0]  = 8'hA5;
      if (dram_ucas_n) m_hold[15:8] = 8'h5A;
    end
  end

  // pin timing monitor, sampled away from the active edge
  bit prev_ras = 1'b1, prev_cas = 1'b0, first_cas = 1'b0, prev_we = 1'b1;
  int low_run = 0, high_run = 1000, cas_low = 0, cas_high = 0, ras_rises = 0;
  logic [8:0] prev_addr = '0;
  always @(negedge clk) begin
    bit ca;
    ca = !dram_lcas_n || !dram_ucas_n;
    if (rst_n) begin
      if (dram_ras_n) begin
        if (!prev_ras) begin
          chk(low_run <= P_RASP, "R9 RAS low run", low_run, P_RASP);
          ras_rises++;
          high_run = 0;
        end
        high_run++;
        low_run = 0;
      end else begin
        if (prev_ras) begin
          chk(high_run >= P_RP, "R8 precharge run", high_run, P_RP);
          first_cas = 1'b1;
        end
        low_run++;
      end
      if (ca && !prev_cas) begin
        chk(prev_addr == dram_addr, "R3 column settled", dram_addr, prev_addr);
        if (first_cas) chk(low_run - 1 == P_RCD + 1, "R3 RAS to CAS", low_run - 1, P_RCD + 1);
        else chk(cas_high >= 2, "R4 CAS precharge", cas_high, 2);
        if (!dram_we_n) begin
          chk(!prev_we, "R6 WE before strobe", prev_we, 0);
          chk(dram_oe_n, "R6 OE high in write", dram_oe_n, 1);
        end
        first_cas = 1'b0;
        cas_low = 0;
      end
      if (!ca && prev_cas) begin
        chk(cas_low == NW, "R7 strobe width", cas_low, NW);
        cas_high = 0;
      end
      if (ca) cas_low++; else cas_high++;
    end
    prev_ras = dram_ras_n; prev_cas = ca; prev_we = dram_we_n; prev_addr = dram_addr;
  end

  task automatic issue(input bit wr, input logic [17:0] a, input logic [1:0] be,
                       input logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    acc_cyc = cyc;
    req_valid = 1'b0;
  endtask

  task automatic do_write(input logic [17:0] a, input logic [1:0] be, input logic [15:0] d);
    logic [15:0] cur;
    issue(1'b1, a, be, d);
    cur = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
    if (be[0]) cur[7:0]  = d[7:0];
    if (be[1]) cur[15:8] = d[15:8];
    shadow[int'(a)] = cur;
  endtask

  task automatic do_read(input logic [17:0] a, input logic [1:0] be, input int lat,
                         input string tag);
    logic [15:0] exp;
    int n;
    exp = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
    if (!be[0]) exp[7:0]  = 8'h00;
    if (!be[1]) exp[15:8] = 8'h00;
    issue(1'b0, a, be, 16'h0);
    n = 0;
    @(negedge clk);
    while (!rd_valid && n < 60) begin @(negedge clk); n++; end
    chk(cyc - acc_cyc == lat, {tag, " latency"}, cyc - acc_cyc, lat);
    chk(rd_data == exp, {tag, " data"}, rd_data, exp);
    @(negedge clk);
    chk(!rd_valid, "R7 pulse width", rd_valid, 0);
  endtask

  localparam int LAT_OPEN = P_RCD + NW + 2;
  localparam int LAT_HIT  = NW + 2;

  task automatic t_reset();
    @(negedge clk);
    chk(dram_ras_n && dram_lcas_n && dram_ucas_n, "R1 strobes high", 0, 1);
    chk(dram_we_n && dram_oe_n && !dram_dq_oe, "R1 WE/OE/driver", 0, 1);
    chk(!rd_valid && !ref_gnt && req_ready, "R1 handshake", {rd_valid, ref_gnt, req_ready}, 1);
  endtask

  task automatic t_page_hit();
    int r0;
    do_write(18'h1ABCD, 2'b11, 16'h1234);
    chk(m_row == 9'h0D5, "R2 row latched", m_row, 9'h0D5);
    r0 = ras_rises;
    do_read(18'h1ABCD, 2'b11, LAT_HIT, "R4 hit read");
    do_write(18'h1AB10, 2'b11, 16'hC0DE);
    do_read(18'h1AB10, 2'b11, LAT_HIT, "R2 second column");
    chk(ras_rises == r0, "R4 RAS held", ras_rises - r0, 0);
  endtask

  task automatic t_miss_lanes();
    int r0;
    r0 = ras_rises;
    do_write(18'h04021, 2'b11, 16'hAAAA);
    chk(ras_rises == r0 + 1, "R8 miss closes", ras_rises - r0, 1);
    do_write(18'h04021, 2'b10, 16'h77FF);
    do_read(18'h04021, 2'b11, LAT_HIT, "R5 word after upper write");
    do_read(18'h04021, 2'b01, LAT_HIT, "R5 low lane only");
    do_read(18'h04021, 2'b10, LAT_HIT, "R5 high lane only");
  endtask

  task automatic t_open_read();
    repeat (P_RASP + 10) @(negedge clk);
    chk(dram_ras_n, "R9 idle page closed", dram_ras_n, 1);
    do_read(18'h3FFFF, 2'b11, LAT_OPEN, "R7 read from closed row");
    do_read(18'h1ABCD, 2'b11, LAT_OPEN, "R8 read after miss");
  endtask

  task automatic t_refresh();
    int n;
    do_read(18'h1AB10, 2'b11, LAT_HIT, "R10 setup read");
    @(negedge clk);
    ref_req = 1'b1;
    n = 0;
    while (!ref_gnt && n < 40) begin @(negedge clk); n++; end
    chk(ref_gnt, "R10 grant", ref_gnt, 1);
    chk(dram_ras_n && dram_lcas_n && dram_ucas_n, "R10 quiet under grant", dram_ras_n, 1);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 18'h1ABCD; req_be = 2'b11;
    repeat (5) begin
      @(negedge clk);
      chk(!req_ready && dram_ras_n, "R10 no access under grant", req_ready, 0);
    end
    req_valid = 1'b0;
    ref_req = 1'b0;
    do_read(18'h1ABCD, 2'b11, LAT_OPEN, "R10 after release");
  endtask

  initial begin
    #200000000;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_page_hit();
    t_miss_lanes();
    t_open_read();
    t_refresh();
    repeat (10) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule